// File: doc/BRIEF.md
# Staged Frequency Command Controller

This block is the control core of a programmable clock source. It sits behind a byte-wide register port and holds a 32-bit frequency word, a driver-mode byte, an output-enable bit, a command byte and a read-only status byte. Software writes a new frequency and mode. Those writes are only staged. A later command makes the staged values take effect.

A write to the command byte is taken in on the following clock edge. At that point the byte clears to zero and the code is carried out. Some codes move the power state between standby and running. Some restart the controller. Four apply codes push the staged values to a tuning engine through a request/done handshake. A refresh code copies the live values back into the staged registers. An apply or refresh that arrives while the controller is busy is dropped without effect.

The block drives one enable toward the output driver. That enable is high only when the controller is running, the enable bit is set, the live mode is non-zero and no output-off apply is in progress.

Top module: `freq_cmd_ctrl`

## Requirements
- R1: Writes to the four frequency bytes or the mode byte are staged only, and may come in any order. The frequency word is big-endian: base address holds bits 31:24 and base+3 holds bits 7:0. The staged values read back as written, and neither `tune_req` nor `drv_oe` changes.
- R2: A written command code reads back in the cycle after the write. The controller then accepts it and clears the byte, so it reads 0 from the cycle after that.
- R3: The status byte uses these bits: bit 7 busy, bit 4 transition, bit 3 reset, bit 2 tuning, bit 1 running, bit 0 standby. The patterns are standby 0x01, running 0x02, running and tuning 0x86, standby to running 0x11, running to standby 0x12, reset taken 0x08 and reset in progress 0x18.
- R4: Code 1 from running shows 0x12 for TRANS_CYC cycles and then 0x01. `drv_oe` goes low from the first of those cycles. Code 2 from standby shows 0x11 for TRANS_CYC cycles and then 0x02.
- R5: An apply (codes 8 to 11) whose staged values differ from the live ones does the following:
  - It raises `tune_req` in the cycle after acceptance, with `tune_freq` and `tune_mode` set to the staged values.
  - It holds those outputs until `tune_done`.
  - After `tune_done`, status returns to 0x02 and the live values are updated.
- R6: Apply codes with bit 1 clear (8, 9) hold `drv_oe` low while the change is processed. Codes with bit 1 set (10, 11) leave `drv_oe` running.
- R7: An apply with bit 0 clear and no difference issues no tuning request. It sets busy for SHORT_CYC cycles and leaves `drv_oe` on. An apply with bit 0 set issues a request even when nothing differs.
- R8: An apply or refresh accepted while busy is dropped. It issues no new request and does not overwrite the staged registers.
- R9: Code 12 copies the live frequency and mode into the staged registers and sets busy for SHORT_CYC cycles.
- R10: A live mode of 0 forces `drv_oe` low. So does clearing the enable bit, which is bit 0 of the enable register.
- R11: Codes 4 and 5 abort any tuning request and show 0x08 for one cycle, then 0x18 for RST_CYC cycles. The controller then returns to its start state with the default frequency, mode and enable bit, both staged and live.
- R12: Codes 0, 3, 6, 7 and 13 to 255 are accepted and cleared, with no effect on status or `drv_oe`.
- R13: A command written in the same cycle that the previous command is accepted is kept. Both commands are carried out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, combinational from registered state |
| tune_req | output | 1 | Tuning request, held until done |
| tune_freq | output | 32 | Frequency word sent with the request |
| tune_mode | output | 8 | Driver mode sent with the request |
| tune_done | input | 1 | Tuning engine completion |
| drv_oe | output | 1 | Output driver enable |

## Verification
Two events can meet in one cycle:
- the acceptance of one command, which clears the command byte;
- a fresh write to that same byte.

The bench provokes this by writing code 1 and then code 2 on consecutive cycles. It expects status 0x12 and then 0x11 on the two cycles that follow, and finally 0x02. A similar overlap happens when an apply or refresh is accepted while tuning is still in flight. The bench checks that the original request fields stay put and that the newly staged bytes survive the dropped refresh.

// File: rtl/freq_cmd_pkg.sv
package freq_cmd_pkg;

  typedef enum logic [2:0] {
    PS_READY, PS_R2A, PS_ACTIVE, PS_A2R, PS_RST_ACC, PS_RST_DOWN
  } pstate_t;

  typedef enum logic [1:0] {AP_IDLE, AP_SHORT, AP_WAIT} apstate_t;

  localparam logic [7:0] CMD_READY   = 8'd1;
  localparam logic [7:0] CMD_ACTIVE  = 8'd2;
  localparam logic [7:0] CMD_SYSRST  = 8'd4;
  localparam logic [7:0] CMD_PORRST  = 8'd5;
  localparam logic [7:0] CMD_REFRESH = 8'd12;

  // codes 8..11: bit1 keeps output running, bit0 forces the update
  function automatic logic is_apply(input logic [7:0] c);
    return c[7:2] == 6'd2;
  endfunction

  function automatic logic values_differ(input logic [31:0] fa, input logic [31:0] fb,
                                         input logic [7:0] ma, input logic [7:0] mb);
    return (fa != fb) || (ma != mb);
  endfunction

  function automatic logic [7:0] status_encode(input pstate_t ps, input logic busy,
                                               input logic tuning);
    logic [7:0] s;
    case (ps)
      PS_READY:    s = 8'h01;
      PS_R2A:      s = 8'h11;
      PS_ACTIVE:   s = {5'b0, tuning, 2'b10};
      PS_A2R:      s = 8'h12;
      PS_RST_ACC:  s = 8'h08;
      PS_RST_DOWN: s = 8'h18;
      default:     s = 8'h00;
    endcase
    if (ps != PS_RST_ACC && ps != PS_RST_DOWN) s[7] = busy;
    return s;
  endfunction

endpackage

// File: rtl/freq_cmd_regs.sv
module freq_cmd_regs import freq_cmd_pkg::*; #(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] FREQ_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] OE_ADDR   = 'h21,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h22,
  parameter logic [31:0]      DEF_FREQ  = 32'h4C8583B0,
  parameter logic [7:0]       DEF_MODE  = 8'h03,
  parameter bit               DEF_OE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [7:0]        status,
  input  logic              refresh_load,
  input  logic [31:0]       act_freq,
  input  logic [7:0]        act_mode,
  input  logic              restore,
  output logic [31:0]       stg_freq,
  output logic [7:0]        stg_mode,
  output logic              oe_bit,
  output logic [7:0]        cmd_code
);
  // command byte sits right after the big-endian frequency word
  localparam logic [ADDR_W-1:0] CMD_ADDR = FREQ_ADDR + ADDR_W'(4);

  logic cmd_hit;
  assign cmd_hit = wr_en && (wr_addr == CMD_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n || restore) begin
      stg_freq <= DEF_FREQ;
      stg_mode <= DEF_MODE;
      oe_bit   <= DEF_OE;
    end else begin
      if (refresh_load) begin
        stg_freq <= act_freq;
        stg_mode <= act_mode;
      end
      for (int i = 0; i < 4; i++)
        if (wr_en && wr_addr == FREQ_ADDR + ADDR_W'(i))
          stg_freq[31-8*i -: 8] <= wr_data;
      if (wr_en && wr_addr == MODE_ADDR) stg_mode <= wr_data;
      if (wr_en && wr_addr == OE_ADDR)   oe_bit   <= wr_data[0];
    end
  end

  // a pending code is taken on the next edge; a new write wins that edge
  always_ff @(posedge clk) begin
    if (!rst_n)       cmd_code <= '0;
    else if (cmd_hit) cmd_code <= wr_data;
    else              cmd_code <= '0;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < 4; i++)
      if (rd_addr == FREQ_ADDR + ADDR_W'(i)) rd_data = stg_freq[31-8*i -: 8];
    if (rd_addr == CMD_ADDR)  rd_data = cmd_code;
    if (rd_addr == MODE_ADDR) rd_data = stg_mode;
    if (rd_addr == OE_ADDR)   rd_data = {7'b0, oe_bit};
    if (rd_addr == STAT_ADDR) rd_data = status;
  end

  a_r2_cmd_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != '0 && !cmd_hit) |=> cmd_code == '0);

endmodule

// File: rtl/freq_cmd_power.sv
module freq_cmd_power import freq_cmd_pkg::*; #(
  parameter bit START_ACTIVE = 1'b1,
  parameter int TRANS_CYC    = 4,
  parameter int RST_CYC      = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_ready,
  input  logic    go_active,
  input  logic    go_reset,
  output pstate_t pstate,
  output logic    in_reset,
  output logic    reset_done
);
  localparam int      CMAX = (TRANS_CYC > RST_CYC) ? TRANS_CYC : RST_CYC;
  localparam int      CW   = $clog2(CMAX + 1);
  localparam pstate_t HOME = START_ACTIVE ? PS_ACTIVE : PS_READY;

  logic [CW-1:0] cnt;

  assign in_reset   = (pstate == PS_RST_ACC) || (pstate == PS_RST_DOWN);
  assign reset_done = (pstate == PS_RST_DOWN) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate <= HOME;
      cnt    <= '0;
    end else if (go_reset) begin
      pstate <= PS_RST_ACC;
      cnt    <= '0;
    end else begin
      case (pstate)
        PS_READY:
          if (go_active) begin pstate <= PS_R2A; cnt <= CW'(TRANS_CYC - 1); end
        PS_ACTIVE:
          if (go_ready) begin pstate <= PS_A2R; cnt <= CW'(TRANS_CYC - 1); end
        PS_R2A:
          if (go_ready) begin pstate <= PS_A2R; cnt <= CW'(TRANS_CYC - 1); end
          else if (cnt == '0) pstate <= PS_ACTIVE;
          else cnt <= cnt - CW'(1);
        PS_A2R:
          if (go_active) begin pstate <= PS_R2A; cnt <= CW'(TRANS_CYC - 1); end
          else if (cnt == '0) pstate <= PS_READY;
          else cnt <= cnt - CW'(1);
        PS_RST_ACC: begin
          pstate <= PS_RST_DOWN;
          cnt    <= CW'(RST_CYC - 1);
        end
        PS_RST_DOWN:
          if (cnt == '0) pstate <= HOME;
          else cnt <= cnt - CW'(1);
        default: pstate <= HOME;
      endcase
    end
  end

  a_r11_reset_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == PS_RST_ACC && !go_reset) |=> pstate == PS_RST_DOWN);

  a_r4_ready_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
    (go_ready && !go_reset) |=> pstate != PS_ACTIVE);

endmodule

// File: rtl/freq_cmd_apply.sv
module freq_cmd_apply import freq_cmd_pkg::*; #(
  parameter logic [31:0] DEF_FREQ  = 32'h4C8583B0,
  parameter logic [7:0]  DEF_MODE  = 8'h03,
  parameter int          SHORT_CYC = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        apply_cmd,
  input  logic        refresh_cmd,
  input  logic        keep_on,
  input  logic        force_upd,
  input  logic        abort,
  input  logic [31:0] stg_freq,
  input  logic [7:0]  stg_mode,
  input  logic        tune_done,
  output logic        busy,
  output logic        tuning,
  output logic        hold_off,
  output logic        tune_req,
  output logic [31:0] tune_freq,
  output logic [7:0]  tune_mode,
  output logic [31:0] act_freq,
  output logic [7:0]  act_mode,
  output logic        refresh_load
);
  localparam int SW = $clog2(SHORT_CYC + 1);

  apstate_t      st;
  logic [SW-1:0] scnt;
  logic          differ, launch;

  assign differ       = values_differ(stg_freq, act_freq, stg_mode, act_mode);
  assign busy         = (st != AP_IDLE);
  assign tuning       = (st == AP_WAIT);
  assign refresh_load = refresh_cmd && (st == AP_IDLE);
  assign launch       = apply_cmd && (st == AP_IDLE) && (differ || force_upd);

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      st        <= AP_IDLE;
      scnt      <= '0;
      tune_req  <= 1'b0;
      hold_off  <= 1'b0;
      tune_freq <= DEF_FREQ;
      tune_mode <= DEF_MODE;
      act_freq  <= DEF_FREQ;
      act_mode  <= DEF_MODE;
    end else begin
      case (st)
        AP_IDLE:
          if (launch) begin
            st        <= AP_WAIT;
            tune_req  <= 1'b1;
            tune_freq <= stg_freq;
            tune_mode <= stg_mode;
            hold_off  <= !keep_on;
          end else if (apply_cmd || refresh_cmd) begin
            st   <= AP_SHORT;
            scnt <= SW'(SHORT_CYC - 1);
          end
        AP_SHORT:
          if (scnt == '0) st <= AP_IDLE;
          else scnt <= scnt - SW'(1);
        AP_WAIT:
          if (tune_done) begin
            act_freq <= tune_freq;
            act_mode <= tune_mode;
            tune_req <= 1'b0;
            hold_off <= 1'b0;
            st       <= AP_IDLE;
          end
        default: st <= AP_IDLE;
      endcase
    end
  end

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_req && !tune_done && !abort) |=> tune_req && $stable(tune_freq) && $stable(tune_mode));

  a_r7_plain_nochange: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_cmd && st == AP_IDLE && !differ && !force_upd && !abort) |=> !tune_req && busy);

  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_cmd && st == AP_SHORT && !abort) |=> !tune_req);

endmodule

// File: rtl/freq_cmd_ctrl.sv
module freq_cmd_ctrl import freq_cmd_pkg::*; #(
  parameter int               ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] FREQ_ADDR    = 'h10,
  parameter logic [ADDR_W-1:0] MODE_ADDR    = 'h20,
  parameter logic [ADDR_W-1:0] OE_ADDR      = 'h21,
  parameter logic [ADDR_W-1:0] STAT_ADDR    = 'h22,
  parameter logic [31:0]      DEF_FREQ     = 32'h4C8583B0,
  parameter logic [7:0]       DEF_MODE     = 8'h03,
  parameter bit               DEF_OE       = 1'b1,
  parameter bit               START_ACTIVE = 1'b1,
  parameter int               TRANS_CYC    = 4,
  parameter int               SHORT_CYC    = 3,
  parameter int               RST_CYC      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              tune_req,
  output logic [31:0]       tune_freq,
  output logic [7:0]        tune_mode,
  input  logic              tune_done,
  output logic              drv_oe
);
  logic [31:0] stg_freq, act_freq;
  logic [7:0]  stg_mode, act_mode, cmd_code, status;
  logic        oe_bit, refresh_load, reset_done, in_reset;
  logic        busy, tuning, hold_off;
  pstate_t     pstate;

  // named command events
  logic live, go_ready, go_active, go_reset, apply_cmd, refresh_cmd;
  assign live        = (cmd_code != '0) && !in_reset;
  assign go_ready    = live && (cmd_code == CMD_READY);
  assign go_active   = live && (cmd_code == CMD_ACTIVE);
  assign go_reset    = live && (cmd_code == CMD_SYSRST || cmd_code == CMD_PORRST);
  assign apply_cmd   = live && is_apply(cmd_code);
  assign refresh_cmd = live && (cmd_code == CMD_REFRESH);

  assign status = status_encode(pstate, busy, tuning);
  assign drv_oe = (pstate == PS_ACTIVE) && oe_bit && (act_mode != '0) && !hold_off;

  freq_cmd_regs #(
    .ADDR_W(ADDR_W), .FREQ_ADDR(FREQ_ADDR), .MODE_ADDR(MODE_ADDR), .OE_ADDR(OE_ADDR),
    .STAT_ADDR(STAT_ADDR), .DEF_FREQ(DEF_FREQ), .DEF_MODE(DEF_MODE), .DEF_OE(DEF_OE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .status(status), .refresh_load(refresh_load),
    .act_freq(act_freq), .act_mode(act_mode), .restore(reset_done),
    .stg_freq(stg_freq), .stg_mode(stg_mode), .oe_bit(oe_bit), .cmd_code(cmd_code)
  );

  freq_cmd_power #(
    .START_ACTIVE(START_ACTIVE), .TRANS_CYC(TRANS_CYC), .RST_CYC(RST_CYC)
  ) u_power (
    .clk(clk), .rst_n(rst_n), .go_ready(go_ready), .go_active(go_active),
    .go_reset(go_reset), .pstate(pstate), .in_reset(in_reset), .reset_done(reset_done)
  );

  freq_cmd_apply #(
    .DEF_FREQ(DEF_FREQ), .DEF_MODE(DEF_MODE), .SHORT_CYC(SHORT_CYC)
  ) u_apply (
    .clk(clk), .rst_n(rst_n), .apply_cmd(apply_cmd), .refresh_cmd(refresh_cmd),
    .keep_on(cmd_code[1]), .force_upd(cmd_code[0]), .abort(go_reset),
    .stg_freq(stg_freq), .stg_mode(stg_mode), .tune_done(tune_done),
    .busy(busy), .tuning(tuning), .hold_off(hold_off), .tune_req(tune_req),
    .tune_freq(tune_freq), .tune_mode(tune_mode), .act_freq(act_freq),
    .act_mode(act_mode), .refresh_load(refresh_load)
  );

  a_r3_one_power_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status[1:0]));

  a_r4_ready_kills_oe: assert property (@(posedge clk) disable iff (!rst_n)
    go_ready |=> !drv_oe);

  a_r11_reset_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    go_reset |=> !tune_req && status == 8'h08);

endmodule

// File: tb/freq_cmd_ctrl_test.sv
module freq_cmd_ctrl_test;
  localparam int TRANS = 4, SHORT = 3, RSTC = 6;
  localparam logic [7:0] FA = 8'h10, CA = 8'h14, MA = 8'h20, OA = 8'h21, SA = 8'h22;
  localparam logic [31:0] F0 = 32'h4C8583B0, F1 = 32'h4B189680, F2 = 32'h4A989680;
  // {code, expected settled status}
  localparam logic [15:0] VEC [9] = '{16'h0002, 16'h0302, 16'h0602, 16'h0D02,
                                      16'h0101, 16'h0701, 16'h0101, 16'h0202, 16'hFF02};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, tune_done = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data, tune_mode;
  logic [31:0] tune_freq;
  logic tune_req, drv_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  freq_cmd_ctrl #(.TRANS_CYC(TRANS), .SHORT_CYC(SHORT), .RST_CYC(RSTC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tune_req(tune_req), .tune_freq(tune_freq),
    .tune_mode(tune_mode), .tune_done(tune_done), .drv_oe(drv_oe));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd_freq(output logic [31:0] f);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd(FA + 8'(i), b);
      f[31-8*i -: 8] = b;
    end
  endtask

  task automatic wr_freq(input logic [31:0] f);
    wr(FA + 8'd3, f[7:0]); wr(FA + 8'd1, f[23:16]);
    wr(FA, f[31:24]);      wr(FA + 8'd2, f[15:8]);
  endtask

  task automatic st_is(input string tag, input logic [7:0] exp);
    logic [7:0] s;
    rd(SA, s);
    chk(tag, {24'b0, s}, {24'b0, exp});
  endtask

  task automatic done_pulse;
    @(negedge clk); tune_done = 1'b1;
    @(negedge clk); tune_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] f;
    step(3); rst_n = 1'b1; step(1);
    // reset state
    st_is("R3 reset status", 8'h02);
    chk("R10 reset drv_oe", drv_oe, 1);
    chk("R5 reset tune_req", tune_req, 0);
    rd_freq(f); chk("R1 reset freq", f, F0);
    rd(MA, b); chk("R1 reset mode", b, 8'h03);

    // vector walk: reserved codes, state changes
    for (int k = 0; k < 9; k++) begin
      wr(CA, VEC[k][15:8]);
      rd(CA, b); chk("R2 cmd readback", b, VEC[k][15:8]);
      step(1); rd(CA, b); chk("R2 cmd cleared", b, 0);
      step(TRANS + 1);
      st_is("R12 status after code", VEC[k][7:0]);
      chk("R12 drv_oe after code", drv_oe, VEC[k][7:0] == 8'h02);
    end

    // R4 transitions
    wr(CA, 8'd1); step(1);
    st_is("R4 to-ready trans", 8'h12); chk("R4 oe off", drv_oe, 0);
    step(TRANS - 1); st_is("R4 still trans", 8'h12);
    step(1); st_is("R4 ready", 8'h01);
    wr(CA, 8'd2); step(1); st_is("R4 to-active trans", 8'h11);
    step(TRANS); st_is("R4 active", 8'h02); chk("R4 oe on", drv_oe, 1);

    // R1 staging
    wr_freq(F1); wr(MA, 8'h05);
    rd_freq(f); chk("R1 staged freq", f, F1);
    rd(MA, b); chk("R1 staged mode", b, 8'h05);
    chk("R1 no req", tune_req, 0); chk("R1 oe kept", drv_oe, 1);

    // R5/R6/R8 apply with change, busy drops
    wr(CA, 8'd8); step(1);
    chk("R5 req", tune_req, 1); chk("R5 freq", tune_freq, F1); chk("R5 mode", tune_mode, 8'h05);
    st_is("R3 tuning status", 8'h86); chk("R6 oe held off", drv_oe, 0);
    wr_freq(F2); wr(CA, 8'd10); step(1); wr(CA, 8'd12); step(1);
    chk("R8 freq stable", tune_freq, F1); chk("R8 req held", tune_req, 1);
    rd_freq(f); chk("R8 refresh dropped", f, F2);
    done_pulse;
    st_is("R5 back to active", 8'h02); chk("R5 req low", tune_req, 0); chk("R6 oe back", drv_oe, 1);

    // R9 refresh
    wr(CA, 8'd12); step(1); st_is("R9 busy", 8'h82);
    rd_freq(f); chk("R9 freq refreshed", f, F1);
    rd(MA, b); chk("R9 mode refreshed", b, 8'h05);
    step(SHORT); st_is("R9 idle", 8'h02);

    // R7 unchanged plain vs force
    wr(CA, 8'd8); step(1);
    chk("R7 no req", tune_req, 0); st_is("R7 short busy", 8'h82); chk("R7 oe on", drv_oe, 1);
    step(SHORT - 1); st_is("R7 busy end", 8'h82);
    step(1); st_is("R7 idle", 8'h02);
    wr(CA, 8'd9); step(1); chk("R7 force req", tune_req, 1); chk("R7 force freq", tune_freq, F1);
    done_pulse;

    // R6 active variant keeps output
    wr_freq(F2); wr(CA, 8'd11); step(1);
    chk("R6 req", tune_req, 1); chk("R6 oe running", drv_oe, 1);
    done_pulse; st_is("R6 done", 8'h02);

    // R10 mode zero and enable bit
    wr(MA, 8'h00); wr(CA, 8'd10); step(1); chk("R10 oe during", drv_oe, 1);
    done_pulse; chk("R10 mode0 oe", drv_oe, 0); st_is("R10 status", 8'h02);
    wr(MA, 8'h05); wr(CA, 8'd10); step(1); done_pulse; chk("R10 mode5 oe", drv_oe, 1);
    wr(OA, 8'h00); chk("R10 oe bit off", drv_oe, 0);
    wr(OA, 8'h01); chk("R10 oe bit on", drv_oe, 1);

    // R13 back to back commands
    @(negedge clk); wr_en = 1'b1; wr_addr = CA; wr_data = 8'd1;
    @(negedge clk); wr_data = 8'd2;
    @(negedge clk); wr_en = 1'b0;
    st_is("R13 first cmd", 8'h12);
    step(1); st_is("R13 second cmd", 8'h11);
    step(TRANS); st_is("R13 settled", 8'h02);

    // R11 reset during tuning
    wr_freq(F1); wr(CA, 8'd8); step(1); chk("R11 req before", tune_req, 1);
    wr(CA, 8'd4); step(1);
    st_is("R11 accepted", 8'h08); chk("R11 req aborted", tune_req, 0);
    step(1); st_is("R11 shutting down", 8'h18);
    step(RSTC - 1); st_is("R11 last down", 8'h18);
    step(1); st_is("R11 home", 8'h02);
    rd_freq(f); chk("R11 default freq", f, F0);
    rd(MA, b); chk("R11 default mode", b, 8'h03);
    rd(OA, b); chk("R11 default oe", b, 8'h01);
    wr(CA, 8'd8); step(1); chk("R11 live restored", tune_req, 0);
    step(SHORT);
    wr(CA, 8'd5); step(1); st_is("R11 por accepted", 8'h08);
    step(RSTC + 1); st_is("R11 por home", 8'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule